// File: doc/BRIEF.md
# Virtual Address Segment Translator with Fault Capture

This block takes one 32-bit virtual address per request and sorts it into one of five fixed regions of the address space. It looks only at the top address bits and at the privilege and error-level state. Two kernel regions translate with no lookup: a fixed offset is subtracted from the address. The user region and the two upper kernel regions are sent to an external page-table lookup port. That port answers combinationally in the same cycle. The block then merges the lookup outcome with the access direction to produce an exception kind and a refill flag.

The translated address, the fault strobe and the exception kind are combinational outputs in the request cycle. When a fault is raised, three capture registers are loaded on the next rising clock edge:
- the faulting-address register,
- the page-table context register,
- the page-tag register.

The upper part of the context value comes from a page-table base input. The low bits of the page tag come from the current address-space identifier input.

Top module: `vseg_xlate`

## Requirements
- R1: With `user_mode`=1, any request whose address bit 31 is 1 faults with an address error: kind 4 on a read (`is_write`=0), kind 5 on a write. `tlb_req` stays 0 and `refill` stays 0.
- R2: A request in 0x00000000–0x7FFFFFFF (other than the R3 case) asserts `tlb_req` and drives `tlb_vaddr` with the address. When `tlb_res`=0 (hit), `phys_addr` equals `tlb_paddr` and no fault is raised.
- R3: With `user_mode`=1 and `err_level`=1, an address in 0x00000000–0x7FFFFFFF passes through unchanged to `phys_addr`, with no lookup and no fault.
- R4: In kernel mode, 0x80000000–0x9FFFFFFF maps to the address minus 0x80000000, and 0xA0000000–0xBFFFFFFF maps to the address minus 0xA0000000. Neither range requests a lookup or faults.
- R5: In kernel mode, 0xC0000000–0xDFFFFFFF and 0xE0000000–0xFFFFFFFF both assert `tlb_req`, and on a hit they return `tlb_paddr`.
- R6: A lookup result of `tlb_res`=1 (miss) faults with kind 2 (lookup failure on load) on a read or kind 3 (lookup failure on store) on a write, and sets `refill`=1.
- R7: A lookup result of `tlb_res`=2 (entry not valid) faults with kind 2 on a read or kind 3 on a write, with `refill`=0.
- R8: A lookup result of `tlb_res`=3 (write to a clean page) faults with kind 1 on both reads and writes, with `refill`=0.
- R9: On the clock edge after a fault, `fault_vaddr` holds the faulting address.
- R10: On the clock edge after a fault, `pte_ctx` holds `ptebase` in bits 31:23, address bits 31:13 in bits 22:4, and zero in bits 3:0.
- R11: On the clock edge after a fault, `page_tag` holds address bits 31:13 in bits 31:13, zero in bits 12:8, and `asid` in bits 7:0.
- R12: Without a fault, `fault_valid`=0, `fault_kind`=0 and the three capture registers keep their values. With `req_valid`=0 there is never a fault or a lookup request. All capture registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| vaddr | input | 32 | Virtual address |
| is_write | input | 1 | 1 = store access, 0 = load access |
| user_mode | input | 1 | Requester runs unprivileged |
| err_level | input | 1 | Error-level state flag |
| asid | input | 8 | Current address-space identifier |
| ptebase | input | 9 | Page-table base for context capture |
| tlb_req | output | 1 | Lookup request to the page-table port |
| tlb_vaddr | output | 32 | Address sent to the lookup |
| tlb_res | input | 2 | Lookup outcome: 0 hit, 1 miss, 2 not valid, 3 clean page |
| tlb_paddr | input | 32 | Physical address returned on a hit |
| phys_addr | output | 32 | Translated address; zero when faulting |
| xlate_ok | output | 1 | Request translated without fault |
| fault_valid | output | 1 | Fault strobe |
| fault_kind | output | 3 | Exception kind (0 none, 1..5 as in R1, R6–R8) |
| refill | output | 1 | Fault came from a lookup miss |
| fault_vaddr | output | 32 | Captured faulting address |
| pte_ctx | output | 32 | Captured page-table context |
| page_tag | output | 32 | Captured page tag with identifier |

## Verification
Directed vectors are placed on each region boundary (0x7FFFFFFF/0x80000000, 0x9FFFFFFF/0xA0000000, 0xBFFFFFFF/0xC0000000, 0xDFFFFFFF/0xE0000000, 0xFFFFFFFF). A decode that is one bit short shows up there as a wrong offset or a lookup where none belongs. Each of the four lookup outcomes is applied with both access directions. This separates the miss, invalid and clean-page kinds, and shows whether the refill flag follows only the miss. The user, error-level and kernel combinations are walked over the low and high halves, so the pass-through case is told apart from both the lookup path and the address error. Random addresses, modes and outcomes then confirm that the capture registers update only after faults and hold their values otherwise.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int VA_W   = 32;
  localparam int PAGE_W = 13;
  localparam int ASID_W = 8;
  localparam int PTEB_W = 9;

  typedef enum logic [1:0] {
    LK_HIT   = 2'd0,
    LK_MISS  = 2'd1,
    LK_INVAL = 2'd2,
    LK_CLEAN = 2'd3
  } lk_res_e;

  typedef enum logic [2:0] {
    XK_NONE      = 3'd0,
    XK_CLEAN_WR  = 3'd1,
    XK_LK_LOAD   = 3'd2,
    XK_LK_STORE  = 3'd3,
    XK_ADR_LOAD  = 3'd4,
    XK_ADR_STORE = 3'd5
  } xkind_e;

  typedef enum logic [2:0] {
    RG_USER,
    RG_KDIR_C,
    RG_KDIR_U,
    RG_KMAP_LO,
    RG_KMAP_HI
  } region_e;
endpackage

// File: rtl/vseg_decode.sv
module vseg_decode
  import vseg_pkg::*;
#(
  parameter int AW = VA_W
) (
  input  logic [AW-1:0] vaddr,
  input  logic          user_mode,
  input  logic          err_level,
  output region_e       region,
  output logic          addr_err,
  output logic          need_lookup,
  output logic [AW-1:0] direct_pa
);
  localparam logic [AW-1:0] OFS_C = AW'(32'h8000_0000);
  localparam logic [AW-1:0] OFS_U = AW'(32'hA000_0000);

  always_comb begin
    unique case (vaddr[AW-1 -: 3])
      3'b100:  region = RG_KDIR_C;
      3'b101:  region = RG_KDIR_U;
      3'b110:  region = RG_KMAP_LO;
      3'b111:  region = RG_KMAP_HI;
      default: region = RG_USER;
    endcase
  end

  always_comb begin
    addr_err    = user_mode & vaddr[AW-1];
    need_lookup = 1'b0;
    direct_pa   = '0;
    if (!addr_err) begin
      unique case (region)
        RG_USER: begin
          if (user_mode && err_level) direct_pa = vaddr;
          else                        need_lookup = 1'b1;
        end
        RG_KDIR_C: direct_pa = vaddr - OFS_C;
        RG_KDIR_U: direct_pa = vaddr - OFS_U;
        default:   need_lookup = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/vseg_fault_map.sv
module vseg_fault_map
  import vseg_pkg::*;
(
  input  logic    req_valid,
  input  logic    addr_err,
  input  logic    need_lookup,
  input  logic    is_write,
  input  lk_res_e lk_res,
  output logic    fault,
  output xkind_e  kind,
  output logic    refill
);
  always_comb begin
    kind   = XK_NONE;
    refill = 1'b0;
    if (req_valid) begin
      if (addr_err) begin
        kind = is_write ? XK_ADR_STORE : XK_ADR_LOAD;
      end else if (need_lookup) begin
        unique case (lk_res)
          LK_MISS: begin
            kind   = is_write ? XK_LK_STORE : XK_LK_LOAD;
            refill = 1'b1;
          end
          LK_INVAL: kind = is_write ? XK_LK_STORE : XK_LK_LOAD;
          LK_CLEAN: kind = XK_CLEAN_WR;
          default:  kind = XK_NONE;
        endcase
      end
    end
    fault = (kind != XK_NONE);
  end
endmodule

// File: rtl/vseg_cop_regs.sv
module vseg_cop_regs
  import vseg_pkg::*;
#(
  parameter int AW = VA_W,
  parameter int PW = PAGE_W,
  parameter int IW = ASID_W,
  parameter int BW = PTEB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [AW-1:0] vaddr,
  input  logic [IW-1:0] asid,
  input  logic [BW-1:0] ptebase,
  output logic [AW-1:0] fault_vaddr,
  output logic [AW-1:0] pte_ctx,
  output logic [AW-1:0] page_tag
);
  localparam int VPN_W = AW - PW;
  localparam int CPAD  = AW - BW - VPN_W;
  localparam int TPAD  = PW - IW;

  logic [AW-1:0] fva_d, ctx_d, tag_d;

  always_comb begin
    fva_d = fault_vaddr;
    ctx_d = pte_ctx;
    tag_d = page_tag;
    if (cap_en) begin
      fva_d = vaddr;
      ctx_d = {ptebase, vaddr[AW-1:PW], {CPAD{1'b0}}};
      tag_d = {vaddr[AW-1:PW], {TPAD{1'b0}}, asid};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_vaddr <= '0;
      pte_ctx     <= '0;
      page_tag    <= '0;
    end else begin
      fault_vaddr <= fva_d;
      pte_ctx     <= ctx_d;
      page_tag    <= tag_d;
    end
  end
endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
  import vseg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] vaddr,
  input  logic        is_write,
  input  logic        user_mode,
  input  logic        err_level,
  input  logic [7:0]  asid,
  input  logic [8:0]  ptebase,
  output logic        tlb_req,
  output logic [31:0] tlb_vaddr,
  input  logic [1:0]  tlb_res,
  input  logic [31:0] tlb_paddr,
  output logic [31:0] phys_addr,
  output logic        xlate_ok,
  output logic        fault_valid,
  output logic [2:0]  fault_kind,
  output logic        refill,
  output logic [31:0] fault_vaddr,
  output logic [31:0] pte_ctx,
  output logic [31:0] page_tag
);
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  region_e       region;
  logic          addr_err, need_lookup;
  logic [31:0]   direct_pa;
  xkind_e        kind;

  vseg_decode #(.AW(VA_W)) u_decode (
    .vaddr(vaddr), .user_mode(user_mode), .err_level(err_level),
    .region(region), .addr_err(addr_err), .need_lookup(need_lookup),
    .direct_pa(direct_pa)
  );

  vseg_fault_map u_fmap (
    .req_valid(req_valid), .addr_err(addr_err), .need_lookup(need_lookup),
    .is_write(is_write), .lk_res(lk_res_e'(tlb_res)),
    .fault(fault_valid), .kind(kind), .refill(refill)
  );

  vseg_cop_regs #(.AW(VA_W), .PW(PAGE_W), .IW(ASID_W), .BW(PTEB_W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .cap_en(fault_valid), .vaddr(vaddr),
    .asid(asid), .ptebase(ptebase), .fault_vaddr(fault_vaddr),
    .pte_ctx(pte_ctx), .page_tag(page_tag)
  );

  assign tlb_req    = req_valid & need_lookup;
  assign tlb_vaddr  = vaddr;
  assign fault_kind = kind;
  assign xlate_ok   = req_valid & ~fault_valid;

  always_comb begin
    if (!req_valid || fault_valid) phys_addr = '0;
    else if (need_lookup)          phys_addr = tlb_paddr;
    else                           phys_addr = direct_pa;
  end
endmodule

// File: rtl/vseg_xlate_chk.sv
module vseg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] vaddr,
  input logic        is_write,
  input logic        user_mode,
  input logic        err_level,
  input logic        tlb_req,
  input logic [1:0]  tlb_res,
  input logic [31:0] phys_addr,
  input logic        fault_valid,
  input logic [2:0]  fault_kind,
  input logic        refill,
  input logic [31:0] fault_vaddr,
  input logic [31:0] pte_ctx,
  input logic [31:0] page_tag
);
  p_user_high_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && user_mode && vaddr[31]) |->
      (fault_valid && !tlb_req && fault_kind == (is_write ? 3'd5 : 3'd4)));

  p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && user_mode && err_level && !vaddr[31]) |->
      (!tlb_req && !fault_valid && phys_addr == vaddr));

  p_direct_cached_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !user_mode && vaddr[31:29] == 3'b100) |->
      (!tlb_req && phys_addr == {3'b000, vaddr[28:0]}));

  p_refill_only_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refill |-> (tlb_req && tlb_res == 2'd1 && fault_valid));

  p_clean_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req && tlb_res == 2'd3) |-> (fault_kind == 3'd1));

  p_capture_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> (fault_vaddr == $past(vaddr)));

  p_capture_ctx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> (pte_ctx[22:0] == {$past(vaddr[31:13]), 4'b0000}));

  p_capture_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> (page_tag[31:8] == {$past(vaddr[31:13]), 5'b00000}));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |=> ($stable(fault_vaddr) && $stable(pte_ctx) && $stable(page_tag)));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!fault_valid && !tlb_req));
endmodule

bind vseg_xlate vseg_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n_sync), .req_valid(req_valid), .vaddr(vaddr),
  .is_write(is_write), .user_mode(user_mode), .err_level(err_level),
  .tlb_req(tlb_req), .tlb_res(tlb_res), .phys_addr(phys_addr),
  .fault_valid(fault_valid), .fault_kind(fault_kind), .refill(refill),
  .fault_vaddr(fault_vaddr), .pte_ctx(pte_ctx), .page_tag(page_tag)
);

// File: tb/vseg_xlate_tb_top.sv
module vseg_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, is_write, user_mode, err_level;
  logic [31:0] vaddr, tlb_paddr;
  logic [7:0]  asid;
  logic [8:0]  ptebase;
  logic [1:0]  tlb_res;
  logic        tlb_req, xlate_ok, fault_valid, refill;
  logic [31:0] tlb_vaddr, phys_addr, fault_vaddr, pte_ctx, page_tag;
  logic [2:0]  fault_kind;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_fva = 0, m_ctx = 0, m_tag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vseg_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
    .is_write(is_write), .user_mode(user_mode), .err_level(err_level),
    .asid(asid), .ptebase(ptebase), .tlb_req(tlb_req), .tlb_vaddr(tlb_vaddr),
    .tlb_res(tlb_res), .tlb_paddr(tlb_paddr), .phys_addr(phys_addr),
    .xlate_ok(xlate_ok), .fault_valid(fault_valid), .fault_kind(fault_kind),
    .refill(refill), .fault_vaddr(fault_vaddr), .pte_ctx(pte_ctx),
    .page_tag(page_tag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected combinational response from the requirements
  task automatic model(input logic rv, input logic [31:0] a, input logic wr,
                       input logic um, input logic el, input logic [1:0] res,
                       input logic [31:0] tpa,
                       output logic e_lk, output logic e_flt, output logic [2:0] e_kind,
                       output logic e_rf, output logic [31:0] e_pa);
    e_lk = 0; e_flt = 0; e_kind = 0; e_rf = 0; e_pa = 0;
    if (rv) begin
      if (um && a[31]) begin                        // R1
        e_kind = wr ? 3'd5 : 3'd4;
      end else if (!a[31] && um && el) begin        // R3
        e_pa = a;
      end else if (a[31:29] == 3'b100) begin        // R4
        e_pa = a - 32'h8000_0000;
      end else if (a[31:29] == 3'b101) begin        // R4
        e_pa = a - 32'hA000_0000;
      end else begin                                // R2, R5
        e_lk = 1;
        case (res)
          2'd0: e_pa = tpa;
          2'd1: begin e_kind = wr ? 3'd3 : 3'd2; e_rf = 1; end  // R6
          2'd2: e_kind = wr ? 3'd3 : 3'd2;                      // R7
          default: e_kind = 3'd1;                               // R8
        endcase
      end
      e_flt = (e_kind != 0);
    end
  endtask

  task automatic apply(input string tag, input logic rv, input logic [31:0] a,
                       input logic wr, input logic um, input logic el,
                       input logic [1:0] res, input logic [31:0] tpa);
    logic e_lk, e_flt, e_rf;
    logic [2:0] e_kind;
    logic [31:0] e_pa;
    @(negedge clk);
    req_valid = rv; vaddr = a; is_write = wr; user_mode = um; err_level = el;
    tlb_res = res; tlb_paddr = tpa;
    asid = 8'($urandom); ptebase = 9'($urandom);
    model(rv, a, wr, um, el, res, tpa, e_lk, e_flt, e_kind, e_rf, e_pa);
    #1;
    chk({tag, " R2/R5 lookup req"}, 32'(tlb_req), 32'(e_lk));
    if (e_lk) chk({tag, " R2 lookup addr"}, tlb_vaddr, a);
    chk({tag, " R1/R6/R7/R8/R12 fault"}, 32'(fault_valid), 32'(e_flt));
    chk({tag, " R1/R6/R7/R8 kind"}, 32'(fault_kind), 32'(e_kind));
    chk({tag, " R6/R7 refill"}, 32'(refill), 32'(e_rf));
    chk({tag, " R2/R3/R4/R5 phys"}, phys_addr, e_pa);
    chk({tag, " R12 ok"}, 32'(xlate_ok), 32'(rv && !e_flt));
    if (e_flt) begin
      m_fva = a;
      m_ctx = {ptebase, a[31:13], 4'b0000};
      m_tag = {a[31:13], 5'b00000, asid};
    end
    @(posedge clk);
    #1;
    chk({tag, " R9 fault addr reg"}, fault_vaddr, m_fva);
    chk({tag, " R10 context reg"}, pte_ctx, m_ctx);
    chk({tag, " R11 tag reg"}, page_tag, m_tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst_n = 0; req_valid = 0; vaddr = 0; is_write = 0; user_mode = 0;
    err_level = 0; asid = 0; ptebase = 0; tlb_res = 0; tlb_paddr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset fault addr reg", fault_vaddr, 0);
    chk("R12 reset context reg", pte_ctx, 0);
    chk("R12 reset tag reg", page_tag, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);

    // Region boundaries in kernel mode
    apply("R2 top user", 1, 32'h7FFF_FFFF, 0, 0, 0, 2'd0, 32'h1234_5000);
    apply("R4 cached lo", 1, 32'h8000_0000, 0, 0, 0, 2'd1, 32'h0);
    apply("R4 cached hi", 1, 32'h9FFF_FFFF, 1, 0, 0, 2'd1, 32'h0);
    apply("R4 uncached lo", 1, 32'hA000_0000, 0, 0, 0, 2'd3, 32'h0);
    apply("R4 uncached hi", 1, 32'hBFFF_FFFF, 1, 0, 0, 2'd2, 32'h0);
    apply("R5 map lo", 1, 32'hC000_0000, 0, 0, 0, 2'd0, 32'h0ABC_D000);
    apply("R5 map lo end", 1, 32'hDFFF_FFFF, 1, 0, 0, 2'd0, 32'h0000_0FFF);
    apply("R5 map hi", 1, 32'hE000_0000, 0, 0, 1, 2'd0, 32'h5555_AAAA);
    apply("R5 map top", 1, 32'hFFFF_FFFF, 1, 0, 0, 2'd0, 32'hDEAD_BEEF);
    // User mode and error level
    apply("R1 user high read", 1, 32'h8000_0000, 0, 1, 0, 2'd0, 32'h0);
    apply("R1 user high write", 1, 32'hFFFF_E123, 1, 1, 1, 2'd0, 32'h0);
    apply("R3 passthru", 1, 32'h1234_5678, 1, 1, 1, 2'd1, 32'hFFFF_FFFF);
    apply("R2 user lookup", 1, 32'h0000_0000, 0, 1, 0, 2'd0, 32'h4000_0000);
    apply("R2 kernel el", 1, 32'h0040_0000, 0, 0, 1, 2'd0, 32'h0100_0000);
    // Every lookup outcome with both directions
    for (int r = 1; r < 4; r++)
      for (int w = 0; w < 2; w++)
        apply("R6/R7/R8 outcome", 1, 32'h2468_ACE0 + 32'(r * 32'h10000 + w),
              1'(w), 0, 0, 2'(r), 32'h0);
    // Idle cycles must not fault nor touch registers
    apply("R12 idle", 0, 32'hFFFF_FFFF, 1, 1, 0, 2'd1, 32'h0);
    apply("R12 idle map", 0, 32'hC000_1000, 0, 0, 0, 2'd3, 32'h0);

    for (int i = 0; i < 400; i++)
      apply("random", 1'($urandom_range(0, 7) != 0), $urandom, 1'($urandom),
            1'($urandom), 1'($urandom), 2'($urandom), $urandom);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule